// File: doc/BRIEF.md
# Auto-Increment Memory Window Controller

This block sits between a 16-bit microcontroller bus and two external memories, a Flash device and a RAM. The bus reaches only 64K bytes directly. To reach further, the block turns pairs of bus addresses into windows. One address in a pair is a position register. Writing it loads a word pointer. The other address is a data port. Each access to the data port lands in external memory at the pointer, and the pointer then moves on by one word. A CPU can stream a whole block of words through one fixed address, with no page switching in its program.

There are four channels, each with its own pointer and its own pair of addresses: Flash read, Flash write, RAM read and RAM write. The block receives an already separated address and data bus, plus the active-low read and write strobes. It produces a 16-bit word address for the memories, which carries the memory address bits 16 down to 1. It also produces one active-low window select for each device.

For any address that is not a data port, the output is the bus word address with the top bit cleared. The data ports place the 64K-word window anywhere in a 128K-byte device. A small bus-cycle state machine follows each strobe and applies the pointer update once, after the strobe ends. The machine has four states. In ST_IDLE no strobe is active. ST_READ and ST_WRITE last while a strobe is low. ST_RETIRE lasts one cycle and applies the update. Its transitions are as follows. ST_IDLE goes to ST_READ when the read strobe is low, otherwise to ST_WRITE when the write strobe is low. ST_READ goes to ST_RETIRE when the read strobe rises. ST_WRITE goes to ST_RETIRE when the write strobe rises. ST_RETIRE always goes back to ST_IDLE.

Top module: `mwin_ctrl`

## Requirements
- R1: When a write strobe ends at a channel's pointer address, the 16-bit write data becomes that channel's pointer.
- R2: While the bus address is a channel's data port, the memory address output equals that channel's pointer. The select of the channel's device is driven low. Flash read and Flash write drive `flash_win_cs_n`; RAM read and RAM write drive `ram_win_cs_n`. At most one select is low at any time.
- R3: Each completed read or write strobe at a data port adds one to that channel's pointer after the strobe ends. The pointer wraps from FFFFh to 0000h.
- R4: For any other bus address, pointer addresses included, the memory address output is {0, bus_addr[15:1]} and both selects are high.
- R5: Bus address bit 0 takes no part in decoding. An odd address selects the same port or pointer as the even address below it.
- R6: An access to one channel leaves the pointers of the other three channels unchanged.
- R7: A read strobe at a pointer address leaves that pointer unchanged.
- R8: A strobe held low for many cycles changes the pointer exactly once. The output address stays constant while the strobe is held low.
- R9: Reset clears all four pointers to 0000h and returns the bus-cycle state machine to ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Demultiplexed byte address from the CPU |
| bus_wdata | input | 16 | Write data from the CPU |
| rd_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| mem_addr | output | 16 | Word address to the memories (memory address bits 16..1) |
| flash_win_cs_n | output | 1 | Low while a Flash window data port is addressed |
| ram_win_cs_n | output | 1 | Low while a RAM window data port is addressed |

## Verification
The bench fills a Flash block and a RAM block through their write windows and reads both back through the read windows, checking every address and data word. A design that advanced the pointer before the strobe ended would return each word one place late. One test reloads a pointer in the middle of a block. Another crosses the FFFFh wrap, which catches a pointer that saturates or that carries into the unused bit. The bench reads a pointer address, touches the other channels and then continues with the first one. This catches decoding that ignores direction, and catches shared or cross-wired pointers. An odd-address access and a strobe held low for six cycles expose a decoder that looks at bit 0, or an update that repeats on every clock of a long strobe.

// File: rtl/mwin_pkg.sv
package mwin_pkg;

    // Number of window channels; their order is fixed because the device
    // select logic treats indices below CH_FLASH_COUNT as Flash channels.
    localparam int unsigned NCH            = 4;
    localparam int unsigned CH_FLASH_COUNT = 2;

    typedef enum logic [1:0] {
        CH_FLASH_RD = 2'd0,
        CH_FLASH_WR = 2'd1,
        CH_RAM_RD   = 2'd2,
        CH_RAM_WR   = 2'd3
    } chan_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_RETIRE = 2'd3
    } bus_st_e;

    function automatic logic chan_is_flash(input int unsigned idx);
        return idx < CH_FLASH_COUNT;
    endfunction

endpackage

// File: rtl/mwin_decode.sv
module mwin_decode
    import mwin_pkg::*;
#(
    parameter int unsigned   AW         = 16,
    parameter logic [NCH*AW-1:0] PTR_ADDRS  = '0,
    parameter logic [NCH*AW-1:0] PORT_ADDRS = '0
) (
    input  logic [AW-1:1]  waddr,
    output logic [NCH-1:0] ptr_hit,
    output logic [NCH-1:0] port_hit
);

    // Word-granular compare: byte lane bit 0 never reaches this module.
    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        localparam logic [AW-1:1] PTR_W  = PTR_ADDRS[g*AW+1 +: AW-1];
        localparam logic [AW-1:1] PORT_W = PORT_ADDRS[g*AW+1 +: AW-1];
        assign ptr_hit[g]  = (waddr == PTR_W);
        assign port_hit[g] = (waddr == PORT_W);
    end

endmodule

// File: rtl/mwin_bus_fsm.sv
module mwin_bus_fsm
    import mwin_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic          we_n,
    input  logic [AW-1:1] waddr,
    input  logic [AW-1:0] wdata,
    output logic          retire,
    output logic          retire_wr,
    output logic [AW-1:1] ret_waddr,
    output logic [AW-1:0] ret_data
);

    bus_st_e       st_q, st_d;
    logic [AW-1:1] waddr_q;
    logic [AW-1:0] data_q;
    logic          wr_q;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!rd_n)      st_d = ST_READ;
                else if (!we_n) st_d = ST_WRITE;
            end
            ST_READ:   if (rd_n) st_d = ST_RETIRE;
            ST_WRITE:  if (we_n) st_d = ST_RETIRE;
            ST_RETIRE: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Address and data are tracked while a strobe is low, so the values seen
    // at the last strobe-low edge are the ones the retire cycle applies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr_q <= '0;
            data_q  <= '0;
            wr_q    <= 1'b0;
        end else if (!rd_n || !we_n) begin
            waddr_q <= waddr;
            data_q  <= wdata;
            wr_q    <= !we_n;
        end
    end

    // Outputs.
    always_comb begin
        retire = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_READ, ST_WRITE: retire = 1'b0;
            ST_RETIRE:                  retire = 1'b1;
            default:                    retire = 1'b0;
        endcase
        retire_wr = wr_q;
        ret_waddr = waddr_q;
        ret_data  = data_q;
    end

    // R8: one retire per strobe, never back to back.
    p_retire_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    // R8: a retire cycle only follows a strobe that has already been released.
    p_retire_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> $past(rd_n && we_n));

endmodule

// File: rtl/mwin_ptr.sv
module mwin_ptr #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] load_val,
    input  logic          inc_en,
    output logic [AW-1:0] ptr
);

    logic [AW-1:0] ptr_q;

    // Load wins over increment; the two never coincide on one bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (load_en) ptr_q <= load_val;
        else if (inc_en)  ptr_q <= ptr_q + 1'b1;
    end

    assign ptr = ptr_q;

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (ptr == $past(load_val)));

    p_inc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !load_en) |=> (ptr == $past(ptr) + 1'b1));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !load_en) |=> $stable(ptr));

endmodule

// File: rtl/mwin_ctrl.sv
module mwin_ctrl
    import mwin_pkg::*;
#(
    parameter int unsigned AW             = 16,
    parameter logic [AW-1:0] FLASH_RD_PTR  = 16'h1F00,
    parameter logic [AW-1:0] FLASH_RD_PORT = 16'h1F02,
    parameter logic [AW-1:0] FLASH_WR_PTR  = 16'h1F04,
    parameter logic [AW-1:0] FLASH_WR_PORT = 16'h1F06,
    parameter logic [AW-1:0] RAM_RD_PTR    = 16'h1F08,
    parameter logic [AW-1:0] RAM_RD_PORT   = 16'h1F0A,
    parameter logic [AW-1:0] RAM_WR_PTR    = 16'h1F0C,
    parameter logic [AW-1:0] RAM_WR_PORT   = 16'h1F0E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [AW-1:0] bus_wdata,
    input  logic          rd_n,
    input  logic          we_n,
    output logic [AW-1:0] mem_addr,
    output logic          flash_win_cs_n,
    output logic          ram_win_cs_n
);

    // Channel index 0 sits in the least significant slice.
    localparam logic [NCH*AW-1:0] PTR_ADDRS  =
        {RAM_WR_PTR, RAM_RD_PTR, FLASH_WR_PTR, FLASH_RD_PTR};
    localparam logic [NCH*AW-1:0] PORT_ADDRS =
        {RAM_WR_PORT, RAM_RD_PORT, FLASH_WR_PORT, FLASH_RD_PORT};

    logic [NCH-1:0] live_ptr_hit, live_port_hit;
    logic [NCH-1:0] ret_ptr_hit, ret_port_hit;
    logic           retire, retire_wr;
    logic [AW-1:1]  ret_waddr;
    logic [AW-1:0]  ret_data;
    logic [AW-1:0]  ptr [NCH];

    // Live decode drives the memory address during the strobe.
    mwin_decode #(.AW(AW), .PTR_ADDRS(PTR_ADDRS), .PORT_ADDRS(PORT_ADDRS)) u_live_dec (
        .waddr    (bus_addr[AW-1:1]),
        .ptr_hit  (live_ptr_hit),
        .port_hit (live_port_hit)
    );

    mwin_bus_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_n      (rd_n),
        .we_n      (we_n),
        .waddr     (bus_addr[AW-1:1]),
        .wdata     (bus_wdata),
        .retire    (retire),
        .retire_wr (retire_wr),
        .ret_waddr (ret_waddr),
        .ret_data  (ret_data)
    );

    // Retire decode picks the channel whose pointer the finished cycle moves.
    mwin_decode #(.AW(AW), .PTR_ADDRS(PTR_ADDRS), .PORT_ADDRS(PORT_ADDRS)) u_ret_dec (
        .waddr    (ret_waddr),
        .ptr_hit  (ret_ptr_hit),
        .port_hit (ret_port_hit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        mwin_ptr #(.AW(AW)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (retire && retire_wr && ret_ptr_hit[g]),
            .load_val (ret_data),
            .inc_en   (retire && ret_port_hit[g]),
            .ptr      (ptr[g])
        );
    end

    // Memory address and device selects.
    always_comb begin
        mem_addr       = {1'b0, bus_addr[AW-1:1]};
        flash_win_cs_n = 1'b1;
        ram_win_cs_n   = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (live_port_hit[i]) begin
                mem_addr = ptr[i];
                if (chan_is_flash(i)) flash_win_cs_n = 1'b0;
                else                  ram_win_cs_n   = 1'b0;
            end
        end
    end

    p_cs_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~flash_win_cs_n, ~ram_win_cs_n}));

    p_direct_top_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_win_cs_n && ram_win_cs_n) |-> !mem_addr[AW-1]);

    p_ptr_addr_is_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|live_ptr_hit) |-> (flash_win_cs_n && ram_win_cs_n));

    p_a0_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(bus_addr[AW-1:1]) && !$stable(bus_addr[0]) && !retire && !$past(retire))
        |-> ($stable(mem_addr) && $stable(flash_win_cs_n) && $stable(ram_win_cs_n)));

    p_stable_in_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && $past(!rd_n) && $stable(bus_addr)) |-> $stable(mem_addr));

endmodule

// File: tb/mwin_ctrl_bench.sv
module mwin_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 21;

    // Vector: [55:52] requirement, [51:50] op (0 read+data check,
    // 1 write, 2 read without data check), [49:34] bus address,
    // [33:18] write data or expected read data, [17:2] expected mem_addr,
    // [1:0] expected {flash_win_cs_n, ram_win_cs_n}.
    localparam logic [55:0] VEC [NVEC] = '{
        {4'd4, 2'd1, 16'h1F04, 16'h8000, 16'h0F82, 2'b11}, // R4 load Flash write pointer
        {4'd2, 2'd1, 16'h1F06, 16'h1111, 16'h8000, 2'b01}, // R2
        {4'd3, 2'd1, 16'h1F06, 16'h2222, 16'h8001, 2'b01}, // R3
        {4'd3, 2'd1, 16'h1F06, 16'h3333, 16'h8002, 2'b01}, // R3
        {4'd3, 2'd1, 16'h1F06, 16'h4444, 16'h8003, 2'b01}, // R3
        {4'd1, 2'd1, 16'h1F00, 16'h8000, 16'h0F80, 2'b11}, // R1 load Flash read pointer
        {4'd1, 2'd0, 16'h1F02, 16'h1111, 16'h8000, 2'b01}, // R1
        {4'd3, 2'd0, 16'h1F02, 16'h2222, 16'h8001, 2'b01}, // R3
        {4'd1, 2'd1, 16'h1F00, 16'h8002, 16'h0F80, 2'b11}, // R1 mid-block reload
        {4'd1, 2'd0, 16'h1F02, 16'h3333, 16'h8002, 2'b01}, // R1
        {4'd1, 2'd1, 16'h1F0C, 16'hFFFF, 16'h0F86, 2'b11}, // R1 RAM write pointer
        {4'd2, 2'd1, 16'h1F0E, 16'hAAAA, 16'hFFFF, 2'b10}, // R2
        {4'd5, 2'd1, 16'h1F0F, 16'hBBBB, 16'h0000, 2'b10}, // R5 odd address, R3 wrap
        {4'd1, 2'd1, 16'h1F08, 16'hFFFF, 16'h0F84, 2'b11}, // R1 RAM read pointer
        {4'd2, 2'd0, 16'h1F0A, 16'hAAAA, 16'hFFFF, 2'b10}, // R2
        {4'd3, 2'd0, 16'h1F0A, 16'hBBBB, 16'h0000, 2'b10}, // R3 wrap on read side
        {4'd6, 2'd0, 16'h1F02, 16'h4444, 16'h8003, 2'b01}, // R6 Flash read undisturbed
        {4'd7, 2'd2, 16'h1F04, 16'h0000, 16'h0F82, 2'b11}, // R7 read of pointer address
        {4'd7, 2'd1, 16'h1F06, 16'h5555, 16'h8004, 2'b01}, // R7 pointer kept
        {4'd4, 2'd2, 16'h3456, 16'h0000, 16'h1A2B, 2'b11}, // R4 direct address
        {4'd5, 2'd0, 16'h1F03, 16'h5555, 16'h8004, 2'b01}  // R5 odd read port
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        rd_n = 1'b1;
    logic        we_n = 1'b1;
    logic [15:0] mem_addr;
    logic        flash_win_cs_n, ram_win_cs_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [15:0] fmem [logic [15:0]];
    logic [15:0] rmem [logic [15:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    mwin_ctrl u_mwin_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .rd_n           (rd_n),
        .we_n           (we_n),
        .mem_addr       (mem_addr),
        .flash_win_cs_n (flash_win_cs_n),
        .ram_win_cs_n   (ram_win_cs_n)
    );

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One bus cycle; the strobe stays low for 'hold' clocks. The memory models
    // are updated from the address and selects seen at the end of the strobe.
    task automatic bus_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input int hold, output logic [15:0] ma_first,
                          output logic [15:0] ma_last, output logic [1:0] cs,
                          output logic [15:0] rdata);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        if (wr) we_n = 1'b0; else rd_n = 1'b0;
        @(negedge clk);
        ma_first = mem_addr;
        for (int k = 1; k < hold; k++) @(negedge clk);
        ma_last = mem_addr;
        cs      = {flash_win_cs_n, ram_win_cs_n};
        rdata   = 16'hDEAD;
        if (wr) begin
            if (cs == 2'b01) fmem[ma_last] = d;
            if (cs == 2'b10) rmem[ma_last] = d;
        end else begin
            if (cs == 2'b01 && fmem.exists(ma_last)) rdata = fmem[ma_last];
            if (cs == 2'b10 && rmem.exists(ma_last)) rdata = rmem[ma_last];
        end
        we_n = 1'b1;
        rd_n = 1'b1;
        @(negedge clk);
        bus_addr = 16'h0000;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] ma0, ma1, rd;
        logic [1:0]  cs;

        // R9: outputs while in reset with a direct address on the bus.
        repeat (3) @(negedge clk);
        check(9, "reset mem_addr", mem_addr, 16'h0000);
        check(9, "reset selects", {14'd0, flash_win_cs_n, ram_win_cs_n}, 16'h0003);
        rst_n = 1'b1;

        // R9: first Flash read port access uses the cleared pointer.
        bus_op(1'b0, 16'h1F02, 16'h0, 2, ma0, ma1, cs, rd);
        check(9, "flash read ptr after reset", ma1, 16'h0000);
        check(2, "flash select on read port", {14'd0, cs}, 16'h0001);

        // Table walk.
        for (int v = 0; v < NVEC; v++) begin
            logic [55:0] e;
            e = VEC[v];
            bus_op(e[51:50] == 2'd1, e[49:34], e[33:18], 2, ma0, ma1, cs, rd);
            check(int'(e[55:52]), $sformatf("vec%0d mem_addr", v), ma1, e[17:2]);
            check(int'(e[55:52]), $sformatf("vec%0d selects", v), {14'd0, cs}, {14'd0, e[1:0]});
            if (e[51:50] == 2'd0)
                check(int'(e[55:52]), $sformatf("vec%0d read data", v), rd, e[33:18]);
        end

        // R8: long write strobe moves the pointer exactly once.
        bus_op(1'b1, 16'h1F0C, 16'h0100, 2, ma0, ma1, cs, rd);
        bus_op(1'b1, 16'h1F0E, 16'h7777, 6, ma0, ma1, cs, rd);
        check(8, "long strobe first addr", ma0, 16'h0100);
        check(8, "long strobe last addr", ma1, 16'h0100);
        bus_op(1'b1, 16'h1F0E, 16'h8888, 2, ma0, ma1, cs, rd);
        check(8, "single step after long strobe", ma1, 16'h0101);

        // R9: reset in mid run clears every pointer.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_op(1'b1, 16'h1F0E, 16'h9999, 2, ma0, ma1, cs, rd);
        check(9, "RAM write ptr after reset", ma1, 16'h0000);
        bus_op(1'b0, 16'h1F02, 16'h0, 2, ma0, ma1, cs, rd);
        check(9, "Flash read ptr after reset", ma1, 16'h0000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule